// File: doc/BRIEF.md
# Four-Slice Logic Cell with Shared Configuration

This block is a programmable logic cell that works on a 4-bit data slice. One set of configuration bits controls all four bit positions, so every slice computes the same function on its own inputs. The core is a single truth table with K inputs. Each slice reads it through its own multiplexer-tree port. A 4-bit register follows the table, and two output buses present either the combinational result or the register contents. The second bus can also be switched off.

The configuration is shifted in serially while the configuration enable is high. It holds the truth table and six mode bits. The mode bits choose the following:
- whether the top table input of every slice comes from a shared control wire;
- whether the slice result comes from an external per-slice sum input (from a separate carry block) or from the table;
- whether the register loads from the result or directly from a 4-bit pin;
- the source of each output bus.

Clock, clock-enable, reset and the control wire are single signals shared by all slices. The outputs have no meaning until the configuration has been fully shifted in.

Top module: `lc4_cell`

## Requirements
- R1: While `cfg_en` is high, each clock shifts `cfg_sin` into the configuration word at bit 0, and the older bits move one place toward the MSB. A 22-bit word is therefore loaded by presenting its MSB first. While `cfg_en` is low, the configuration holds. Layout: [15:0] truth table, [16] use-sum, [17] control-on, [18] register-from-pin, [19] out_a-from-register, [21:20] out_b mode.
- R2: Slice s (0..3) forms an index from `lut_in[4s+3:4s]`, with bit 3 as the MSB. Its result is the truth-table bit at that index.
- R3: All four slices use the same table and mode bits. Slices with equal inputs therefore give equal results.
- R4: When control-on is 1, bit 3 of every slice's index is replaced by `ctl_in`.
- R5: When use-sum is 1, the result of slice s is `sum_in[s]`. Otherwise it is the raw table output.
- R6: A synchronous high `rst` clears all four register bits on the next edge. It takes priority over `reg_en`.
- R7: When `reg_en` is high and `rst` is low, the register loads `reg_pin` if register-from-pin is 1, and the slice results otherwise. When `reg_en` is low, the register holds.
- R8: `out_a` shows the register when out_a-from-register is 1, and the combinational result otherwise.
- R9: In out_b mode 00, `out_b` shows the result. In mode 01 it shows the register. In both modes `out_b_oe` is 1. In modes 10 and 11, `out_b_oe` is 0 and `out_b` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous register clear, active high |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_sin | input | 1 | Configuration serial input |
| lut_in | input | 16 | Table inputs, 4 bits per slice |
| ctl_in | input | 1 | Shared control wire for table input 3 |
| sum_in | input | 4 | Per-slice sum from the carry block |
| reg_en | input | 1 | Shared register clock-enable |
| reg_pin | input | 4 | Direct register data |
| out_a | output | 4 | Result or register |
| out_b | output | 4 | Result, register, or 0 when off |
| out_b_oe | output | 1 | Output enable for out_b |

## Verification
A synchronous reset and an enabled register load can arrive in the same cycle. The bench provokes this by raising `rst` together with `reg_en`, with `reg_pin` set to all ones. It then requires the register, read through `out_a`, to be zero after the edge. One cycle later it requires the pin value to appear once `rst` falls. A second overlap is a register load while `out_b` is switched off. The bench judges this by checking that `out_b_oe` stays 0 and that `out_a` still tracks the register.

// File: rtl/lc4_pkg.sv
package lc4_pkg;

    typedef enum logic [1:0] {
        OB_COMB = 2'b00,
        OB_REG  = 2'b01,
        OB_OFFA = 2'b10,
        OB_OFFB = 2'b11
    } outb_mode_e;

    // Mode bits sit above the truth table in the configuration word.
    typedef struct packed {
        outb_mode_e outb;          // [5:4]
        logic       a_from_reg;    // [3]
        logic       reg_from_pin;  // [2]
        logic       ctl_on;        // [1]
        logic       use_sum;       // [0]
    } mode_t;

    localparam int unsigned MODE_W = $bits(mode_t);

endpackage

// File: rtl/lc4_cfg_chain.sv
module lc4_cfg_chain #(
    parameter int unsigned WIDTH = 22
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             sin,
    output logic [WIDTH-1:0] bits_o
);
    typedef struct packed {
        logic [WIDTH-1:0] chain;
    } chain_t;

    chain_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (shift_en) begin
            ch_d.chain = {ch_q.chain[WIDTH-2:0], sin};
        end
    end

    always_ff @(posedge clk) begin
        ch_q <= ch_d;
    end

    assign bits_o = ch_q.chain;
endmodule

// File: rtl/lc4_read_port.sv
module lc4_read_port #(
    parameter int unsigned K = 4
) (
    input  logic [(1<<K)-1:0] table_i,
    input  logic [K-1:0]      sel_i,
    output logic              bit_o
);
    localparam int unsigned DEPTH = 1 << K;

    // Heap-ordered tree: node 1 is the root, leaves are DEPTH..2*DEPTH-1.
    logic [2*DEPTH-1:1] node;

    assign node[2*DEPTH-1:DEPTH] = table_i;

    for (genvar i = 1; i < DEPTH; i++) begin : g_node
        localparam int unsigned LVL = $clog2(i + 1) - 1;
        assign node[i] = sel_i[K-1-LVL] ? node[2*i+1] : node[2*i];
    end

    assign bit_o = node[1];
endmodule

// File: rtl/lc4_out_stage.sv
module lc4_out_stage
    import lc4_pkg::*;
#(
    parameter int unsigned SLICES = 4
) (
    input  logic [SLICES-1:0] result_i,
    input  logic [SLICES-1:0] reg_i,
    input  logic              a_from_reg,
    input  outb_mode_e        outb_mode,
    output logic [SLICES-1:0] out_a,
    output logic [SLICES-1:0] out_b,
    output logic              out_b_oe
);
    always_comb begin
        out_a = a_from_reg ? reg_i : result_i;
        unique case (outb_mode)
            OB_COMB: begin out_b = result_i; out_b_oe = 1'b1; end
            OB_REG:  begin out_b = reg_i;    out_b_oe = 1'b1; end
            default: begin out_b = '0;       out_b_oe = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lc4_cell.sv
module lc4_cell
    import lc4_pkg::*;
#(
    parameter int unsigned SLICES = 4,
    parameter int unsigned K      = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_en,
    input  logic                  cfg_sin,
    input  logic [SLICES*K-1:0]   lut_in,
    input  logic                  ctl_in,
    input  logic [SLICES-1:0]     sum_in,
    input  logic                  reg_en,
    input  logic [SLICES-1:0]     reg_pin,
    output logic [SLICES-1:0]     out_a,
    output logic [SLICES-1:0]     out_b,
    output logic                  out_b_oe
);
    localparam int unsigned TBL_W = 1 << K;
    localparam int unsigned CFG_W = TBL_W + MODE_W;

    logic [CFG_W-1:0]  cfg_bits;
    logic [TBL_W-1:0]  truth;
    mode_t             mode;
    logic [SLICES-1:0] lut_bit;
    logic [SLICES-1:0] result;

    typedef struct packed {
        logic [SLICES-1:0] reg_bits;
    } state_t;

    state_t st_d, st_q;
    logic [SLICES-1:0] reg_q;

    lc4_cfg_chain #(.WIDTH(CFG_W)) u_cfg (
        .clk      (clk),
        .shift_en (cfg_en),
        .sin      (cfg_sin),
        .bits_o   (cfg_bits)
    );

    assign truth = cfg_bits[TBL_W-1:0];
    assign mode  = mode_t'(cfg_bits[CFG_W-1:TBL_W]);

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        logic [K-1:0] idx;
        always_comb begin
            idx = lut_in[s*K +: K];
            if (mode.ctl_on) begin
                idx[K-1] = ctl_in;
            end
        end
        lc4_read_port #(.K(K)) u_port (
            .table_i (truth),
            .sel_i   (idx),
            .bit_o   (lut_bit[s])
        );
        assign result[s] = mode.use_sum ? sum_in[s] : lut_bit[s];
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.reg_bits = '0;
        end else if (reg_en) begin
            st_d.reg_bits = mode.reg_from_pin ? reg_pin : result;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign reg_q = st_q.reg_bits;

    lc4_out_stage #(.SLICES(SLICES)) u_out (
        .result_i   (result),
        .reg_i      (reg_q),
        .a_from_reg (mode.a_from_reg),
        .outb_mode  (mode.outb),
        .out_a      (out_a),
        .out_b      (out_b),
        .out_b_oe   (out_b_oe)
    );
endmodule

// File: rtl/lc4_cell_chk.sv
module lc4_cell_chk
    import lc4_pkg::*;
#(
    parameter int unsigned SLICES = 4,
    parameter int unsigned K      = 4,
    parameter int unsigned CFG_W  = 22
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_en,
    input logic                reg_en,
    input logic [SLICES-1:0]   reg_pin,
    input logic [SLICES*K-1:0] lut_in,
    input logic [SLICES-1:0]   out_a,
    input logic [SLICES-1:0]   out_b,
    input logic                out_b_oe,
    input logic [SLICES-1:0]   reg_q,
    input logic [CFG_W-1:0]    cfg_bits,
    input mode_t               mode
);
    logic slices_equal;
    always_comb begin
        slices_equal = 1'b1;
        for (int s = 1; s < SLICES; s++) begin
            if (lut_in[s*K +: K] != lut_in[K-1:0]) slices_equal = 1'b0;
        end
    end

    a_r1_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> cfg_bits == $past(cfg_bits));

    a_r3_same_result: assert property (@(posedge clk) disable iff (rst)
        (slices_equal && !mode.use_sum && !mode.a_from_reg)
            |-> (out_a == '0 || out_a == '1));

    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> reg_q == '0);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_en |=> reg_q == $past(reg_q));

    a_r7_pin_load: assert property (@(posedge clk) disable iff (rst)
        (reg_en && mode.reg_from_pin) |=> reg_q == $past(reg_pin));

    a_r8_a_reg: assert property (@(posedge clk) disable iff (rst)
        mode.a_from_reg |-> out_a == reg_q);

    a_r9_off: assert property (@(posedge clk) disable iff (rst)
        mode.outb[1] |-> (!out_b_oe && out_b == '0));
endmodule

bind lc4_cell lc4_cell_chk #(.SLICES(SLICES), .K(K), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .reg_en   (reg_en),
    .reg_pin  (reg_pin),
    .lut_in   (lut_in),
    .out_a    (out_a),
    .out_b    (out_b),
    .out_b_oe (out_b_oe),
    .reg_q    (reg_q),
    .cfg_bits (cfg_bits),
    .mode     (mode)
);

// File: tb/lc4_cell_bench.sv
module lc4_cell_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic        cfg_sin = 1'b0;
    logic [15:0] lut_in = '0;
    logic        ctl_in = 1'b0;
    logic [3:0]  sum_in = '0;
    logic        reg_en = 1'b0;
    logic [3:0]  reg_pin = '0;
    logic [3:0]  out_a, out_b;
    logic        out_b_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lc4_cell u_lc4_cell (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
        .lut_in(lut_in), .ctl_in(ctl_in), .sum_in(sum_in),
        .reg_en(reg_en), .reg_pin(reg_pin),
        .out_a(out_a), .out_b(out_b), .out_b_oe(out_b_oe)
    );

    // {table, ctl_on, use_sum, ctl, lut_in, sum}
    localparam logic [38:0] VEC [NVEC] = '{
        {16'hAAAA, 1'b0, 1'b0, 1'b0, 16'h3210, 4'h0},
        {16'h8000, 1'b0, 1'b0, 1'b0, 16'hF7FF, 4'h0},
        {16'h6996, 1'b0, 1'b0, 1'b0, 16'h8421, 4'h0},
        {16'hFFFE, 1'b0, 1'b0, 1'b0, 16'h0100, 4'h0},
        {16'h00FF, 1'b1, 1'b0, 1'b1, 16'h0F0F, 4'h0},
        {16'h00FF, 1'b1, 1'b0, 1'b0, 16'hF8F8, 4'h0},
        {16'h1234, 1'b0, 1'b1, 1'b0, 16'hABCD, 4'h9},
        {16'hCAFE, 1'b0, 1'b0, 1'b0, 16'h7777, 4'h0}
    };

    function automatic logic [21:0] mk_cfg(logic [15:0] tbl, logic use_sum,
            logic ctl_on, logic from_pin, logic a_reg, logic [1:0] ob);
        return {ob, a_reg, from_pin, ctl_on, use_sum, tbl};
    endfunction

    function automatic logic [3:0] ref_res(logic [15:0] tbl, logic ctl_on,
            logic use_sum, logic ctl, logic [15:0] li, logic [3:0] sm);
        logic [3:0] r;
        for (int s = 0; s < 4; s++) begin
            logic [3:0] idx;
            idx = li[s*4 +: 4];
            if (ctl_on) idx[3] = ctl;
            r[s] = use_sum ? sm[s] : tbl[idx];
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg(logic [21:0] w);
        for (int i = 21; i >= 0; i--) begin
            cfg_en = 1'b1;
            cfg_sin = w[i];
            tick();
        end
        cfg_en = 1'b0;
        cfg_sin = 1'b0;
    endtask

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;

        // Table walk: R1 R2 R3 R4 R5 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] exp;
            load_cfg(mk_cfg(VEC[v][38:23], VEC[v][21], VEC[v][22], 1'b0, 1'b0, 2'b00));
            ctl_in = VEC[v][20];
            lut_in = VEC[v][19:4];
            sum_in = VEC[v][3:0];
            #1;
            exp = ref_res(VEC[v][38:23], VEC[v][22], VEC[v][21], VEC[v][20],
                          VEC[v][19:4], VEC[v][3:0]);
            check("R2/R4/R5 out_a", out_a, exp);
            check("R9 out_b comb", out_b, exp);
            check("R9 oe comb", {3'b0, out_b_oe}, 4'h1);
        end
        // R3: equal slices from last vector give all-equal bits
        check("R3 equal slices", out_a, (out_a[0] ? 4'hF : 4'h0));

        // R6: reset wins over enable in the same cycle
        load_cfg(mk_cfg(16'hAAAA, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01));
        reg_pin = 4'hF; reg_en = 1'b1; rst = 1'b1;
        tick();
        check("R6 reset over enable", out_a, 4'h0);
        rst = 1'b0;
        tick();
        check("R7 pin load", out_a, 4'hF);
        check("R9 out_b reg", out_b, 4'hF);
        // R7 hold
        reg_en = 1'b0; reg_pin = 4'h5;
        tick(); tick();
        check("R7 hold", out_a, 4'hF);

        // R7 load from table result (reg held during config)
        load_cfg(mk_cfg(16'hAAAA, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01));
        check("R7 hold across config", out_a, 4'hF);
        lut_in = 16'h3210; reg_en = 1'b1;
        tick();
        check("R7 result load", out_a, 4'hA);
        check("R8 out_a reg", out_a, 4'hA);

        // R9 off modes, register load meanwhile
        reg_en = 1'b0;
        load_cfg(mk_cfg(16'hAAAA, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10));
        reg_en = 1'b1; reg_pin = 4'h6;
        tick();
        check("R9 off mode10 data", out_b, 4'h0);
        check("R9 off mode10 oe", {3'b0, out_b_oe}, 4'h0);
        check("R7 load while out_b off", out_a, 4'h6);
        reg_en = 1'b0;
        load_cfg(mk_cfg(16'hAAAA, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11));
        check("R9 off mode11 data", out_b, 4'h0);
        check("R9 off mode11 oe", {3'b0, out_b_oe}, 4'h0);

        // R1: configuration holds while cfg_en is low
        for (int i = 0; i < 6; i++) begin
            cfg_sin = i[0];
            tick();
        end
        lut_in = 16'h3210;
        #1;
        check("R1 cfg hold", out_a, 4'hA);
        lut_in = 16'h0101;
        #1;
        check("R8 out_a comb", out_a, 4'h5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule